// File: doc/BRIEF.md
# Latched Bit and Error Counters

This block keeps two running tallies for bit-error-rate measurement on a receive path. One counts every received bit that is qualified for measurement. The other counts the qualified bits that a pattern comparator upstream has marked as wrong. Counting only happens while the receiver is in sync and receive disable is low. The comparator supplies one valid strobe and one error strobe per receive-clock cycle.

A measurement interval ends on a rising edge of the latch request. The latch request is the OR of a latch-count pin and a latch-count control bit. On that edge, both running counts are copied into holding registers that software reads. The running counts restart in the same cycle, so no bit is lost across the interval boundary.

Each counter is a two-state machine. In state `CNT_RUN` the counter counts. It moves to state `CNT_SAT` when an event arrives while the count is already at all ones. In `CNT_SAT` the count is frozen at all ones and the overflow flag is raised. A latch edge returns the counter to `CNT_RUN` from either state: `RUN->RUN on latch`, `RUN->SAT on event at maximum`, `SAT->RUN on latch`, and `SAT->SAT` otherwise. The holding values are also readable as bytes through a small address decoder.

Top module: `ber_count_latch`

## Requirements
- R1: While `sync_ok`=1 and `rx_off`=0, the bit count advances by one in every cycle with `bit_vld`=1.
- R2: Under the same gating, the error count advances by one in every cycle with both `bit_vld`=1 and `bit_err`=1. The error count never exceeds the bit count.
- R3: While `rx_off`=1, neither count changes.
- R4: While `sync_ok`=0, neither count changes.
- R5: In the cycle where `lat_pin | lat_ctl` first goes from 0 to 1, both running counts are copied into `hold_bits` and `hold_errs`. At all other times the holding values are unchanged.
- R6: The latch edge restarts both running counts. A qualified event in the latch cycle becomes the first count of the new interval, so the new count starts at 1 for that counter.
- R7: Holding the latch request high causes no further latches. Raising the second latch source while the first is already high is not an edge.
- R8: A count already at 2^CNT_W-1 stays there when a further event arrives, and that counter's overflow flag (`ovf_bits` or `ovf_errs`) is set.
- R9: Overflow flags stay set until the next latch edge. The latch edge clears them.
- R10: `rd_data` returns `hold_bits` zero-extended to 32 bits at addresses 08h..0Bh, and `hold_errs` at 0Ch..0Fh. The most significant byte is at the lowest address of each group. Every other address of the 5-bit space reads 00h.
- R11: After reset, all counts and holding values are zero and both flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | A received bit is present this cycle |
| bit_err | input | 1 | The present bit was in error |
| rx_off | input | 1 | Receive disable; stops counting when high |
| sync_ok | input | 1 | Receiver is in sync |
| lat_pin | input | 1 | Latch-count pin |
| lat_ctl | input | 1 | Latch-count control bit |
| rd_addr | input | 5 | Byte read address |
| rd_data | output | 8 | Byte read data |
| hold_bits | output | CNT_W | Latched bit count |
| hold_errs | output | CNT_W | Latched error count |
| ovf_bits | output | 1 | Sticky bit-count overflow flag |
| ovf_errs | output | 1 | Sticky error-count overflow flag |

## Verification
The bench builds the block with `CNT_W`=8, so both counters can be driven past their maximum within a few hundred cycles. This lets the bench exercise the `CNT_RUN` to `CNT_SAT` transition, the sticky flags and the recovery on a latch edge. The bench steps a cycle-accurate arithmetic model beside the design, and compares both holding values and both flags after every clock. It also sweeps all 32 read addresses against bytes computed from the expected holding values, which confirms the zero extension above bit 7.

// File: rtl/ber_pkg.sv
package ber_pkg;
    typedef enum logic {
        CNT_RUN = 1'b0,
        CNT_SAT = 1'b1
    } cnt_state_t;

    localparam int unsigned LANES    = 2;
    localparam int unsigned LANE_BIT = 0;
    localparam int unsigned LANE_ERR = 1;
endpackage

// File: rtl/ber_latch_edge.sv
module ber_latch_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic src_a,
    input  logic src_b,
    output logic fire
);
    logic req, req_q;

    assign req  = src_a | src_b;
    assign fire = req & ~req_q;

    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req;
    end

    // R7: a latch request that stays high produces only a single edge
    assert_single_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);
endmodule

// File: rtl/ber_counter.sv
module ber_counter
    import ber_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] hold,
    output logic         ovf
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    cnt_state_t   state_q, state_d;
    logic [W-1:0] cnt_q;
    logic [W-1:0] hold_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CNT_RUN;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CNT_RUN: begin
                if (clr)                        state_d = CNT_RUN;
                else if (inc && cnt_q == MAXV)  state_d = CNT_SAT;
            end
            CNT_SAT: begin
                if (clr) state_d = CNT_RUN;
            end
        endcase
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            hold_q <= '0;
        end else if (clr) begin
            hold_q <= cnt_q;
            cnt_q  <= inc ? ONE : '0;
        end else if (inc && state_q == CNT_RUN && cnt_q != MAXV) begin
            cnt_q <= cnt_q + ONE;
        end
    end

    // outputs
    always_comb begin
        hold = hold_q;
        ovf  = (state_q == CNT_SAT);
    end

    assert_idle_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !clr) |=> $stable(cnt_q));
    assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> hold_q == $past(cnt_q));
    assert_hold_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> $stable(hold_q));
    assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt_q == {{(W-1){1'b0}}, $past(inc)});
    assert_saturated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> cnt_q == MAXV);
    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr) |=> ovf);
endmodule

// File: rtl/ber_byte_read.sv
module ber_byte_read #(
    parameter int unsigned W = 32
) (
    input  logic [4:0]   addr,
    input  logic [W-1:0] bits_val,
    input  logic [W-1:0] errs_val,
    output logic [7:0]   data
);
    localparam logic [2:0] GRP_BITS = 3'b010; // 08h..0Bh
    localparam logic [2:0] GRP_ERRS = 3'b011; // 0Ch..0Fh

    logic [31:0] bits32, errs32, word;
    logic [1:0]  bsel;

    assign bits32 = 32'(bits_val);
    assign errs32 = 32'(errs_val);
    assign bsel   = 2'd3 - addr[1:0];

    always_comb begin
        if (addr[4:2] == GRP_BITS)      word = bits32;
        else if (addr[4:2] == GRP_ERRS) word = errs32;
        else                            word = '0;
        data = word[bsel*8 +: 8];
    end
endmodule

// File: rtl/ber_count_latch.sv
module ber_count_latch
    import ber_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_vld,
    input  logic             bit_err,
    input  logic             rx_off,
    input  logic             sync_ok,
    input  logic             lat_pin,
    input  logic             lat_ctl,
    input  logic [4:0]       rd_addr,
    output logic [7:0]       rd_data,
    output logic [CNT_W-1:0] hold_bits,
    output logic [CNT_W-1:0] hold_errs,
    output logic             ovf_bits,
    output logic             ovf_errs
);
    logic             qual;
    logic             fire;
    logic [LANES-1:0] lane_inc;
    logic [LANES-1:0] lane_ovf;
    logic [CNT_W-1:0] lane_hold [LANES];

    // R3, R4: counting gated by receive disable and sync
    assign qual               = bit_vld & ~rx_off & sync_ok;
    assign lane_inc[LANE_BIT] = qual;
    assign lane_inc[LANE_ERR] = qual & bit_err;

    ber_latch_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .src_a (lat_pin),
        .src_b (lat_ctl),
        .fire  (fire)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        ber_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (lane_inc[g]),
            .clr   (fire),
            .hold  (lane_hold[g]),
            .ovf   (lane_ovf[g])
        );
    end

    assign hold_bits = lane_hold[LANE_BIT];
    assign hold_errs = lane_hold[LANE_ERR];
    assign ovf_bits  = lane_ovf[LANE_BIT];
    assign ovf_errs  = lane_ovf[LANE_ERR];

    ber_byte_read #(.W(CNT_W)) u_rd (
        .addr     (rd_addr),
        .bits_val (hold_bits),
        .errs_val (hold_errs),
        .data     (rd_data)
    );

    assert_err_le_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hold_errs <= hold_bits);
    assert_err_ovf_implies_bit_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_errs |-> ovf_bits);
endmodule

// File: tb/tb_ber_count_latch.sv
module tb_ber_count_latch;
    localparam int W = 8;
    localparam int MAXV = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_vld = 0, bit_err = 0, rx_off = 0, sync_ok = 1, lat_pin = 0, lat_ctl = 0;
    logic [4:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [W-1:0] hold_bits, hold_errs;
    logic ovf_bits, ovf_errs;

    int checks = 0, errors = 0;
    int mb = 0, me = 0, hb = 0, he = 0;
    bit fb = 0, fe = 0, lprev = 0;
    string tag = "R11";

    always #5 clk = ~clk;

    ber_count_latch #(.CNT_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_err(bit_err),
        .rx_off(rx_off), .sync_ok(sync_ok), .lat_pin(lat_pin), .lat_ctl(lat_ctl),
        .rd_addr(rd_addr), .rd_data(rd_data), .hold_bits(hold_bits),
        .hold_errs(hold_errs), .ovf_bits(ovf_bits), .ovf_errs(ovf_errs)
    );

    task automatic chk(input string t, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", t, act, exp);
        end
    endtask

    // drive one cycle, advance the model, compare after the edge
    task automatic step(input bit v, input bit e, input bit off, input bit sy,
                        input bit p, input bit c);
        bit q, le;
        @(negedge clk);
        bit_vld = v; bit_err = e; rx_off = off; sync_ok = sy; lat_pin = p; lat_ctl = c;
        @(posedge clk);
        q  = v && !off && sy;
        le = (p || c) && !lprev;
        lprev = p || c;
        if (le) begin
            hb = mb; he = me;
            mb = q ? 1 : 0; me = (q && e) ? 1 : 0;
            fb = 0; fe = 0;
        end else if (q) begin
            if (mb == MAXV) fb = 1; else mb++;
            if (e) begin
                if (me == MAXV) fe = 1; else me++;
            end
        end
        #2;
        chk({tag, " hold_bits"}, int'(hold_bits), hb);
        chk({tag, " hold_errs"}, int'(hold_errs), he);
        chk({tag, " ovf_bits"}, int'(ovf_bits), int'(fb));
        chk({tag, " ovf_errs"}, int'(ovf_errs), int'(fe));
    endtask

    task automatic latch_ctl();
        step(0, 0, 0, 1, 0, 1);
        step(0, 0, 0, 1, 0, 0);
    endtask

    task automatic sweep_reads();
        for (int a = 0; a < 32; a++) begin
            int exp;
            rd_addr = 5'(a);
            #1;
            if (a >= 8 && a <= 11)       exp = (hb >> (8 * (11 - a))) & 255;
            else if (a >= 12 && a <= 15) exp = (he >> (8 * (15 - a))) & 255;
            else                         exp = 0;
            chk($sformatf("R10 addr %0d", a), int'(rd_data), exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R11 reset state
        chk("R11 hold_bits", int'(hold_bits), 0);
        chk("R11 hold_errs", int'(hold_errs), 0);
        chk("R11 ovf_bits", int'(ovf_bits), 0);
        chk("R11 ovf_errs", int'(ovf_errs), 0);
        sweep_reads();
        @(negedge clk); rst_n = 1;

        // R1, R2: mixed valid and error patterns
        tag = "R1_R2";
        for (int i = 0; i < 60; i++) step(i % 3 != 0, i % 5 == 0, 0, 1, 0, 0);
        latch_ctl();
        for (int i = 0; i < 40; i++) step(i % 2 == 0, i % 4 == 0, 0, 1, 0, 0);
        latch_ctl();

        // R3 receive disable blocks counting
        tag = "R3";
        for (int i = 0; i < 20; i++) step(1, 1, 1, 1, 0, 0);
        step(0, 0, 0, 1, 1, 0);
        step(0, 0, 0, 1, 0, 0);

        // R4 loss of sync blocks counting
        tag = "R4";
        for (int i = 0; i < 20; i++) step(1, i % 2, 0, 0, 0, 0);
        for (int i = 0; i < 5; i++)  step(1, 0, 0, 1, 0, 0);
        latch_ctl();

        // R5, R7: level-held request latches once; second source is not an edge
        tag = "R5_R7";
        for (int i = 0; i < 7; i++) step(1, i == 3, 0, 1, 0, 0);
        step(0, 0, 0, 1, 1, 0);
        for (int i = 0; i < 9; i++) step(1, 1, 0, 1, 1, 0);
        step(1, 0, 0, 1, 1, 1);
        step(1, 0, 0, 1, 0, 1);
        step(0, 0, 0, 1, 0, 0);
        latch_ctl();

        // R6 event in the latch cycle opens the new interval at one
        tag = "R6";
        for (int i = 0; i < 4; i++) step(1, 1, 0, 1, 0, 0);
        step(1, 1, 0, 1, 0, 1);
        step(0, 0, 0, 1, 0, 0);
        latch_ctl();

        // R8 saturation, R9 sticky flags and recovery
        tag = "R8_R9";
        for (int i = 0; i < MAXV + 20; i++) step(1, 1, 0, 1, 0, 0);
        for (int i = 0; i < 15; i++) step(0, 0, 0, 1, 0, 0);
        latch_ctl();
        latch_ctl();

        // R10 byte readout of distinct counts
        tag = "R10";
        for (int i = 0; i < 200; i++) step(1, i % 3 == 0 && i < 231, 0, 1, 0, 0);
        latch_ctl();
        sweep_reads();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule